// File: doc/BRIEF.md
# Shared-Controller Arbitration Mutex Register

This block is a single arbitration word that lets several independent agents, such as separate firmware images or virtual machines, take turns using one bus controller. An agent claims the controller by writing its nonzero 4-bit identifier into the low nibble of the word. It then reads the word back and checks whether its own identifier appears in the owner nibble. It gives the controller up by writing zero.

Ownership is advisory only. The block never gates access to any other register. Agents are expected to respect an owner that is already in place. The current owner and a busy flag are also driven out as plain signals, so nearby logic can see the lock state without doing a register read.

Access uses a simple strobe-style register port. Writes take effect at the clock edge. Read data is combinational from the current state in the same cycle.

Top module: `sw_mutex_reg`

## Requirements
- R1: Reset (active-low, asynchronous) clears both the owner field and the request field to zero, and `busy_o` reads 0.
- R2: The register responds only at byte address 0x0EC. A write to any other address changes nothing, and a read of any other address returns zero.
- R3: Read data carries the owner identifier in bits [7:4] and the request identifier in bits [3:0]. Bits [31:8] read as zero, and the values written to those bits are ignored.
- R4: A write of a nonzero identifier while the owner field is zero makes that identifier the owner. The request field takes the same value, and both are visible from the next cycle.
- R5: A write of the identifier that already owns the mutex leaves the owner and request fields unchanged.
- R6: A write of a nonzero identifier while a different identifier owns the mutex is ignored.
- R7: A write of zero while the mutex is owned clears both the owner field and the request field to zero.
- R8: A write of zero while the mutex is free leaves both fields at zero.
- R9: `owner_o` always equals the owner field. `busy_o` is 1 exactly when that field is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read, when `acc_i` is high |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read access |
| owner_o | output | 4 | Current owner identifier, 0 when free |
| busy_o | output | 1 | High while a nonzero owner holds the mutex |

## Verification
A write is applied at a falling edge and takes effect at the next rising edge. `owner_o` and `busy_o` therefore change one rising edge after the write strobe. The combinational read that follows shows the new word in that same cycle. The bench drives each write for exactly one cycle, then issues a read at the following falling edge. It samples `rdata_o`, `owner_o` and `busy_o` 1 ns later, which is away from any rising edge. The reset checks sample while reset is held low, because the clear is asynchronous and needs no clock edge.

// File: rtl/sw_mutex_pkg.sv
package sw_mutex_pkg;
  localparam int ID_W      = 4;
  localparam int DATA_W    = 32;
  localparam int REQ_LSB   = 0;
  localparam int GRANT_LSB = REQ_LSB + ID_W;
  localparam int USED_W    = GRANT_LSB + ID_W;

  typedef logic [ID_W-1:0] agent_id_t;
endpackage

// File: rtl/sw_mutex_decode.sv
module sw_mutex_decode #(
  parameter int               ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h0EC
) (
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic hit;
  assign hit      = acc_i && (addr_i == OFFSET);
  assign wr_hit_o = hit && we_i;
  assign rd_hit_o = hit && !we_i;
endmodule

// File: rtl/sw_mutex_arb.sv
module sw_mutex_arb
  import sw_mutex_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  agent_id_t wr_id_i,
  output agent_id_t grant_o,
  output agent_id_t req_o
);
  agent_id_t grant_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      req_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_id_i == '0) begin
        grant_q <= '0;            // release (no-op when already free)
        req_q   <= '0;
      end else if (grant_q == '0) begin
        grant_q <= wr_id_i;       // free: take it
        req_q   <= wr_id_i;
      end
      // owned: same id or foreign id both leave state untouched
    end
  end

  assign grant_o = grant_q;
  assign req_o   = req_q;

  p_acquire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_id_i != '0 && grant_o == '0) |=> (grant_o == $past(wr_id_i) && req_o == $past(wr_id_i)));

  p_hold_owned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_id_i != '0 && grant_o != '0) |=> ($stable(grant_o) && $stable(req_o)));

  p_foreign_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_id_i != '0 && grant_o != '0 && grant_o != wr_id_i) |=> (grant_o == $past(grant_o)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_id_i == '0) |=> (grant_o == '0 && req_o == '0));

  p_free_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_id_i == '0 && grant_o == '0) |=> $stable(grant_o));

  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(grant_o) && $stable(req_o)));
endmodule

// File: rtl/sw_mutex_reg.sv
module sw_mutex_reg
  import sw_mutex_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h0EC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ID_W-1:0]   owner_o,
  output logic              busy_o
);
  logic      wr_hit, rd_hit;
  agent_id_t grant, req;
  logic      unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:ID_W];

  sw_mutex_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_decode (
    .acc_i    (acc_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  sw_mutex_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_hit),
    .wr_id_i (wdata_i[REQ_LSB +: ID_W]),
    .grant_o (grant),
    .req_o   (req)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      rdata_o[GRANT_LSB +: ID_W] = grant;
      rdata_o[REQ_LSB +: ID_W]   = req;
    end
  end

  assign owner_o = grant;
  assign busy_o  = |grant;

  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:USED_W] == '0);

  p_busy_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (owner_o != '0 && $past(owner_o) == '0));

  p_miss_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && addr_i != OFFSET) |-> rdata_o == '0);
endmodule

// File: tb/sw_mutex_reg_tb.sv
`timescale 1ns/1ps
module sw_mutex_reg_tb;
  localparam int N = 11;
  localparam logic [11:0] MX = 12'h0EC;

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [7:0]  exp;   // expected {owner, request} read back at MX
  } vec_t;

  localparam vec_t VECS [N] = '{
    '{MX,     32'h0000_0003, 8'h33},  // R4 acquire when free
    '{MX,     32'h0000_0003, 8'h33},  // R5 owner re-requests
    '{MX,     32'h0000_0005, 8'h33},  // R6 foreign request ignored
    '{MX,     32'h0000_0000, 8'h00},  // R7 release
    '{MX,     32'h0000_0000, 8'h00},  // R8 zero while free
    '{12'h0E8, 32'h0000_0009, 8'h00}, // R2 wrong address
    '{MX,     32'hABCD_EF0A, 8'hAA},  // R3 upper bits ignored
    '{MX,     32'h0000_000C, 8'hAA},  // R6 foreign request ignored
    '{MX,     32'hFFFF_FF00, 8'h00},  // R7 release with junk upper bits
    '{MX,     32'h0000_000F, 8'hFF},  // R4 largest id
    '{MX,     32'h0000_0001, 8'hFF}   // R6 smallest id ignored
  };
  string tags [N] = '{"R4","R5","R6","R7","R8","R2","R3","R6","R7","R4","R6"};

  logic        clk = 0, rst_ni = 0, acc_i = 0, we_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  owner_o;
  logic        busy_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sw_mutex_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_i(acc_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .owner_o(owner_o), .busy_o(busy_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); acc_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); acc_i = 0; we_i = 0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    acc_i = 1; we_i = 0; addr_i = a;
    #1;
    check(tag, rdata_o, exp);
    acc_i = 0;
  endtask

  task automatic port_check(string tag, logic [3:0] own);
    check({tag, " R9 owner"}, {28'h0, owner_o}, {28'h0, own});
    check({tag, " R9 busy"}, {31'h0, busy_o}, {31'h0, own != 4'h0});
  endtask

  initial begin
    #3;
    check("R1 reset owner", {28'h0, owner_o}, 32'h0);
    check("R1 reset busy", {31'h0, busy_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk);
    rd_check("R1 reset read", MX, 32'h0);

    for (int i = 0; i < N; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd_check(tags[i], MX, {24'h0, VECS[i].exp});
      port_check(tags[i], VECS[i].exp[7:4]);
    end

    // R2: owned now (0xF); a read at another offset returns zero
    @(negedge clk);
    rd_check("R2 off-address read", 12'h0F0, 32'h0);

    // R1: asynchronous reset while owned clears everything without a clock edge
    @(negedge clk);
    #0.5 rst_ni = 0;
    #0.5;
    check("R1 async owner", {28'h0, owner_o}, 32'h0);
    check("R1 async busy", {31'h0, busy_o}, 32'h0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    rd_check("R1 after reset read", MX, 32'h0);

    // R4 after reset: new agent can acquire
    wr(MX, 32'h0000_0006);
    rd_check("R4 post-reset acquire", MX, 32'h66);
    port_check("R4", 4'h6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule